// File: doc/BRIEF.md
# Pseudo-Static RAM Power Mode Sequencer

This block drives the two chip-enable pins of a pseudo-static RAM through power-up, standby and deep power-down. It is clocked. Every wait it enforces is given in nanoseconds and converted to clock cycles when the block is built. After reset it holds the memory deselected for the full initialisation wait. It then selects the memory and raises a ready flag, which tells the access controller that the bus is its own. When ready is low, the access controller must leave the memory alone.

A power-down request comes with a depth bit. With the depth bit clear, the request only deselects the memory: the memory keeps refreshing and the data stays valid. With the depth bit set, the memory is deselected and the power pin is then pulled low. This stops refresh, so the block raises a sticky data-lost flag that stays up until it is acknowledged. A wake request brings the memory back. From standby it returns at once. From deep power-down it goes through the same long initialisation wait as power-up. A reinitialise request runs the whole deep power-down entry and exit without further help. This serves as a reset when the power-up timing could not be met. Requests that arrive while the sequencer is busy are not remembered, with one exception: a wake that arrives during the entry or minimum-low phases is kept and acted on.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, mem_ce1_n=1, mem_ce2=1, mem_ready=0 and data_lost=0.
- R2: After reset is released, mem_ce1_n and mem_ce2 both stay high for exactly INIT_C = ceil(INIT_NS/CLK_NS) cycles before mem_ce1_n falls. mem_ready is 1 exactly when mem_ce1_n=0 and mem_ce2=1.
- R3: A power-down request with pd_deep=0, taken while ready, sets mem_ce1_n=1 and mem_ready=0. mem_ce2 stays 1 and data_lost is unchanged, and this standby state holds until a wake request.
- R4: A wake request seen in standby (once the STBY_C-cycle minimum deselect time is over) restores mem_ready with no initialisation wait. mem_ready rises SYNC_STAGES+1 cycles after wake_req is driven.
- R5: A power-down request with pd_deep=1 (from ready or from standby) first raises mem_ce1_n. From ready, mem_ce2 falls after exactly SET_C = ceil(max(CE2_SETUP_NS, CYCLE_NS)/CLK_NS) cycles with mem_ce1_n high. mem_ce2 is never low while mem_ce1_n is low.
- R6: mem_ce2 stays low for at least PD_C = ceil(PD_MIN_NS/CLK_NS) cycles. A wake request that arrives before or during that window is latched, and the exit then starts after exactly PD_C low cycles.
- R7: On exit from deep power-down, mem_ce2 rises while mem_ce1_n is high. Both then stay high for exactly INIT_C cycles before mem_ce1_n falls and mem_ready rises.
- R8: data_lost is set in the cycle mem_ce2 falls. It stays set until lost_ack is sampled high; if setting and acknowledging fall in the same cycle, setting wins.
- R9: reinit_req, taken in ready or standby, runs the deep power-down entry (R5, R6) and the full exit (R7) with no wake request, and sets data_lost.
- R10: pd_req and reinit_req seen while mem_ready=0 and not in standby are ignored and not remembered. wake_req seen while ready is ignored.
- R11: pd_req, pd_deep, wake_req and reinit_req each pass through SYNC_STAGES flip-flops. A request driven before a clock edge changes the chip enables SYNC_STAGES+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_req | input | 1 | Power-down request (level) |
| pd_deep | input | 1 | With pd_req: 1 = deep power-down, 0 = standby |
| wake_req | input | 1 | Wake request from standby or deep power-down |
| reinit_req | input | 1 | Run the deep power-down entry and exit as a reset |
| lost_ack | input | 1 | Clears data_lost |
| mem_ce1_n | output | 1 | Memory chip enable 1, active low |
| mem_ce2 | output | 1 | Memory chip enable 2, low = deep power-down |
| mem_ready | output | 1 | Access controller owns the memory bus |
| data_lost | output | 1 | Memory contents lost since last acknowledge |

## Verification
A wrong state register or a wrong timer load shows at the chip-enable pins within one cycle of the faulty transition. The clearest cases are a phase that is too short or too long, counted in clock cycles, and mem_ce2 dropping while mem_ce1_n is low. The bench counts the cycles each pin combination lasts through power-down setup, minimum low time and initialisation, and compares each count with the figure derived from the nanosecond parameters. A lost wake latch shows up as the memory staying in power-down. A missing hold-off shows up as a power-down some cycles after ready rises.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

   typedef enum logic [2:0] {
      ST_INIT,
      ST_ACTIVE,
      ST_STBY_MIN,
      ST_STBY,
      ST_PD_SETUP,
      ST_PD_MIN,
      ST_PD
   } pwr_state_e;

   typedef struct packed {
      logic ce1_n;
      logic ce2;
      logic ready;
   } pin_set_t;

   // Round a nanosecond figure up to whole clock cycles, never below one.
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      int per;
      int c;
      per = (clk_ns < 1) ? 1 : clk_ns;
      c   = (ns + per - 1) / per;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Pin levels for each state.
   function automatic pin_set_t pins_of(input pwr_state_e s);
      pin_set_t p;
      p.ce1_n = (s != ST_ACTIVE);
      p.ce2   = !((s == ST_PD_MIN) || (s == ST_PD));
      p.ready = (s == ST_ACTIVE);
      return p;
   endfunction

endpackage

// File: rtl/psram_pwr_sync.sv
module psram_pwr_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end

         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/psram_pwr_timer.sv
module psram_pwr_timer #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= W'(RST_VAL);
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_pwr_outs.sv
module psram_pwr_outs
   import psram_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pwr_state_e st_d,
   output logic       ce1_n,
   output logic       ce2,
   output logic       ready
);

   pin_set_t pins_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_q <= '{ce1_n: 1'b1, ce2: 1'b1, ready: 1'b0};
      else        pins_q <= pins_of(st_d);
   end

   assign ce1_n = pins_q.ce1_n;
   assign ce2   = pins_q.ce2;
   assign ready = pins_q.ready;

endmodule

// File: rtl/psram_pwr_lost.sv
module psram_pwr_lost (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (ack_i) flag_o <= 1'b0;
   end

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
   import psram_pwr_pkg::*;
#(
   parameter int CLK_NS       = 20,
   parameter int INIT_NS      = 300000,
   parameter int CE2_SETUP_NS = 10,
   parameter int CYCLE_NS     = 70,
   parameter int PD_MIN_NS    = 80,
   parameter int STBY_MIN_NS  = 10,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_req,
   input  logic pd_deep,
   input  logic wake_req,
   input  logic reinit_req,
   input  logic lost_ack,
   output logic mem_ce1_n,
   output logic mem_ce2,
   output logic mem_ready,
   output logic data_lost
);

   localparam int INIT_C = ns_to_cyc(INIT_NS, CLK_NS);
   localparam int SET_C  = ns_to_cyc(max2(CE2_SETUP_NS, CYCLE_NS), CLK_NS);
   localparam int PD_C   = ns_to_cyc(PD_MIN_NS, CLK_NS);
   localparam int STBY_C = ns_to_cyc(STBY_MIN_NS, CLK_NS);
   localparam int MAX_C  = max2(max2(INIT_C, SET_C), max2(PD_C, STBY_C));
   localparam int TW     = $clog2(MAX_C + 1);

   // R11: requests enter through a synchroniser chain
   logic [3:0] req_raw;
   logic [3:0] req_s;
   logic       s_pd, s_deep, s_wake, s_reinit;

   assign req_raw = {pd_req, pd_deep, wake_req, reinit_req};

   psram_pwr_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_raw),
      .q     (req_s)
   );

   assign {s_pd, s_deep, s_wake, s_reinit} = req_s;

   pwr_state_e    st_q, st_d;
   logic          ld;
   logic [TW-1:0] ld_val;
   logic          tdone;
   logic          pend_q, pend_set, pend_clr;
   logic          lost_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_INIT;
         pend_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (pend_clr)      pend_q <= 1'b0;
         else if (pend_set) pend_q <= 1'b1;
      end
   end

   always_comb begin
      st_d     = st_q;
      ld       = 1'b0;
      ld_val   = '0;
      pend_set = 1'b0;
      pend_clr = 1'b0;
      lost_set = 1'b0;
      case (st_q)
         ST_INIT: begin
            if (tdone) begin
               st_d     = ST_ACTIVE;
               pend_clr = 1'b1;
            end
         end
         ST_ACTIVE: begin
            // R10: wake ignored here; R9 takes priority over R3/R5
            if (s_reinit) begin
               st_d     = ST_PD_SETUP;
               ld       = 1'b1;
               ld_val   = TW'(SET_C - 1);
               pend_set = 1'b1;
            end else if (s_pd && s_deep) begin
               st_d   = ST_PD_SETUP;
               ld     = 1'b1;
               ld_val = TW'(SET_C - 1);
            end else if (s_pd) begin
               st_d   = ST_STBY_MIN;
               ld     = 1'b1;
               ld_val = TW'(STBY_C - 1);
            end
         end
         ST_STBY_MIN: begin
            if (s_wake) pend_set = 1'b1;
            if (tdone)  st_d = ST_STBY;
         end
         ST_STBY: begin
            if (s_wake || pend_q) begin
               st_d     = ST_ACTIVE;
               pend_clr = 1'b1;
            end else if (s_reinit) begin
               st_d     = ST_PD_SETUP;
               ld       = 1'b1;
               ld_val   = TW'(SET_C - 1);
               pend_set = 1'b1;
            end else if (s_pd && s_deep) begin
               st_d   = ST_PD_SETUP;
               ld     = 1'b1;
               ld_val = TW'(SET_C - 1);
            end
         end
         ST_PD_SETUP: begin
            if (s_wake) pend_set = 1'b1;
            if (tdone) begin
               st_d     = ST_PD_MIN;
               ld       = 1'b1;
               ld_val   = TW'(PD_C - 1);
               lost_set = 1'b1;
            end
         end
         ST_PD_MIN: begin
            if (s_wake) pend_set = 1'b1;
            if (tdone) begin
               if (pend_q || s_wake) begin
                  st_d     = ST_INIT;
                  ld       = 1'b1;
                  ld_val   = TW'(INIT_C - 1);
                  pend_clr = 1'b1;
               end else begin
                  st_d = ST_PD;
               end
            end
         end
         ST_PD: begin
            if (s_wake || pend_q) begin
               st_d     = ST_INIT;
               ld       = 1'b1;
               ld_val   = TW'(INIT_C - 1);
               pend_clr = 1'b1;
            end
         end
         default: begin
            st_d = ST_INIT;
            ld     = 1'b1;
            ld_val = TW'(INIT_C - 1);
         end
      endcase
   end

   psram_pwr_timer #(.W(TW), .RST_VAL(INIT_C - 1)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .done     (tdone)
   );

   psram_pwr_outs u_outs (
      .clk   (clk),
      .rst_n (rst_n),
      .st_d  (st_d),
      .ce1_n (mem_ce1_n),
      .ce2   (mem_ce2),
      .ready (mem_ready)
   );

   // R8: sticky loss flag
   psram_pwr_lost u_lost (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (lost_set),
      .ack_i  (lost_ack),
      .flag_o (data_lost)
   );

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
   parameter int PD_C   = 1,
   parameter int INIT_C = 1
) (
   input logic clk,
   input logic rst_n,
   input logic ce1_n,
   input logic ce2,
   input logic ready,
   input logic lost,
   input logic lost_ack
);

   logic [31:0] low_cnt;
   logic [31:0] init_cnt;
   logic        need_init;
   logic        ce2_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (!ce2) begin
         if (low_cnt != 32'hFFFF_FFFF) low_cnt <= low_cnt + 1'b1;
      end else begin
         low_cnt <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         need_init <= 1'b1;
         init_cnt  <= '0;
         ce2_d     <= 1'b1;
      end else begin
         ce2_d <= ce2;
         if (ce2 && !ce2_d) begin
            need_init <= 1'b1;
            init_cnt  <= 32'd1;
         end else if (!ce1_n) begin
            need_init <= 1'b0;
         end else if (need_init && ce2 && init_cnt != 32'hFFFF_FFFF) begin
            init_cnt <= init_cnt + 1'b1;
         end
      end
   end

   p_ce2_needs_ce1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ce2 |-> ce1_n);

   p_ce2_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce2) |-> $past(ce1_n));

   p_ready_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!ce1_n && ce2));

   p_lost_on_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce2) |-> lost);

   p_lost_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lost) |-> $past(lost_ack));

   p_pd_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce2) |-> (low_cnt >= 32'(PD_C)));

   p_exit_ce1_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce2) |-> ce1_n);

   p_init_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ce1_n) && need_init) |-> (init_cnt >= 32'(INIT_C)));

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(.PD_C(PD_C), .INIT_C(INIT_C)) u_pwr_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce1_n    (mem_ce1_n),
   .ce2      (mem_ce2),
   .ready    (mem_ready),
   .lost     (data_lost),
   .lost_ack (lost_ack)
);

// File: tb/test_psram_pwr_seq.sv
module test_psram_pwr_seq;

   localparam int SYNC   = 2;
   localparam int INIT_C = 50;   // 1000 ns / 20 ns
   localparam int SET_C  = 4;    // max(10, 70) ns / 20 ns, rounded up
   localparam int PD_C   = 10;   // 200 ns / 20 ns

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic pd_req = 1'b0, pd_deep = 1'b0, wake_req = 1'b0, reinit_req = 1'b0, lost_ack = 1'b0;
   logic mem_ce1_n, mem_ce2, mem_ready, data_lost;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   psram_pwr_seq #(
      .CLK_NS(20), .INIT_NS(1000), .CE2_SETUP_NS(10), .CYCLE_NS(70),
      .PD_MIN_NS(200), .STBY_MIN_NS(10), .SYNC_STAGES(SYNC)
   ) i_psram_pwr_seq (
      .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .pd_deep(pd_deep),
      .wake_req(wake_req), .reinit_req(reinit_req), .lost_ack(lost_ack),
      .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_ready(mem_ready),
      .data_lost(data_lost)
   );

   // {pd,deep,wake,reinit,ack}, requirement, wait cycles, expected {ce1_n,ce2,ready,lost}
   localparam logic [20:0] TAB [10] = '{
      {5'b10000, 4'd3, 8'd10, 4'b1100},   // R3 standby entry
      {5'b00000, 4'd3, 8'd5,  4'b1100},   // R3 standby holds
      {5'b00100, 4'd4, 8'd10, 4'b0110},   // R4 wake to ready
      {5'b11000, 4'd5, 8'd25, 4'b1001},   // R5 deep power-down, lost set
      {5'b00001, 4'd8, 8'd5,  4'b1000},   // R8 acknowledge
      {5'b00100, 4'd7, 8'd5,  4'b1100},   // R7 exit, in init wait
      {5'b00000, 4'd7, 8'd60, 4'b0110},   // R7 ready after init
      {5'b00010, 4'd9, 8'd30, 4'b1101},   // R9 reinit, in init wait
      {5'b00000, 4'd9, 8'd60, 4'b0111},   // R9 ready, lost still set
      {5'b00001, 4'd8, 8'd5,  4'b0110}    // R8 acknowledge
   };

   function automatic logic [3:0] outs_now();
      return {mem_ce1_n, mem_ce2, mem_ready, data_lost};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      int cnt;
      int c2;
      int c3;
      bit ok;
      logic [3:0] o;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(outs_now() == 4'b1100, "R1 reset outputs", outs_now(), 4'b1100);

      // R2 init length, R10 requests during init are dropped
      rst_n = 1'b1;
      cnt = 0;
      while (mem_ce1_n && cnt < 5000) begin
         cnt++;
         if (cnt == 5) begin pd_req = 1'b1; pd_deep = 1'b1; reinit_req = 1'b1; end
         if (cnt == 8) begin pd_req = 1'b0; pd_deep = 1'b0; reinit_req = 1'b0; end
         @(negedge clk);
      end
      chk(cnt == INIT_C, "R2 init cycles after reset", cnt, INIT_C);
      chk(mem_ready && mem_ce2, "R2 ready after init", {mem_ready, mem_ce2}, 3);
      ok = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!mem_ready || !mem_ce2) ok = 1'b0;
      end
      chk(ok, "R10 request during init not remembered", ok, 1);
      wake_req = 1'b1;
      repeat (2) @(negedge clk);
      wake_req = 1'b0;
      repeat (5) @(negedge clk);
      chk(mem_ready && !mem_ce1_n, "R10 wake ignored while ready", mem_ready, 1);

      // R11 latency, R3 standby
      pd_req = 1'b1; pd_deep = 1'b0;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!mem_ce1_n && cnt < 50);
      chk(cnt == SYNC + 1, "R11 request latency", cnt, SYNC + 1);
      pd_req = 1'b0;
      repeat (5) @(negedge clk);
      chk(outs_now() == 4'b1100, "R3 standby pins", outs_now(), 4'b1100);

      // R4: wake from standby, no init wait
      wake_req = 1'b1;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!mem_ready && cnt < 200);
      chk(cnt == SYNC + 1, "R4 wake from standby latency", cnt, SYNC + 1);
      wake_req = 1'b0;
      repeat (5) @(negedge clk);

      // Vector table walk
      for (int s = 0; s < 10; s++) begin
         {pd_req, pd_deep, wake_req, reinit_req, lost_ack} = TAB[s][20:16];
         repeat (int'(TAB[s][11:4])) @(negedge clk);
         o = outs_now();
         chk(o == TAB[s][3:0], $sformatf("R%0d table step %0d", TAB[s][15:12], s),
             o, TAB[s][3:0]);
      end
      {pd_req, pd_deep, wake_req, reinit_req, lost_ack} = 5'b00000;
      repeat (5) @(negedge clk);

      // R9 reinit with exact phase lengths (R5, R6, R7)
      reinit_req = 1'b1;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!mem_ce1_n && cnt < 50);
      reinit_req = 1'b0;
      cnt = 0;
      while (mem_ce1_n && mem_ce2 && cnt < 500) begin cnt++; @(negedge clk); end
      chk(cnt == SET_C, "R5 ce1 high before ce2 falls", cnt, SET_C);
      c2 = 0;
      while (!mem_ce2 && c2 < 500) begin c2++; @(negedge clk); end
      chk(c2 == PD_C, "R6 ce2 low cycles on reinit", c2, PD_C);
      c3 = 0;
      while (mem_ce1_n && c3 < 500) begin c3++; @(negedge clk); end
      chk(c3 == INIT_C, "R7 init cycles after exit", c3, INIT_C);
      chk(mem_ready && data_lost, "R9 reinit ends ready with lost set",
          {mem_ready, data_lost}, 3);
      lost_ack = 1'b1;
      @(negedge clk);
      lost_ack = 1'b0;
      @(negedge clk);
      chk(!data_lost, "R8 lost cleared by ack", data_lost, 0);

      // R6: wake pulse during minimum low time is latched
      pd_req = 1'b1; pd_deep = 1'b1;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (mem_ce2 && cnt < 100);
      pd_req = 1'b0; pd_deep = 1'b0;
      wake_req = 1'b1;
      c2 = 0;
      while (!mem_ce2 && c2 < 200) begin
         c2++;
         if (c2 == 2) wake_req = 1'b0;
         @(negedge clk);
      end
      wake_req = 1'b0;
      chk(c2 == PD_C, "R6 latched wake exits after min low", c2, PD_C);
      c3 = 0;
      while (mem_ce1_n && c3 < 500) begin c3++; @(negedge clk); end
      chk(c3 == INIT_C && mem_ready, "R7 init after latched wake", c3, INIT_C);
      chk(data_lost, "R8 lost still set before ack", data_lost, 1);
      lost_ack = 1'b1;
      @(negedge clk);
      lost_ack = 1'b0;
      @(negedge clk);
      chk(!data_lost, "R8 final ack clears lost", data_lost, 0);

      finish_run();
   end

endmodule